// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block turns a 64-bit effective fetch address into a real address for the instruction fetch path, and it decides in the same cycle whether the fetch may proceed. Each page number maps to exactly one slot. The slot number is a hash that XOR-folds three slices of the page number, so that pages far apart in the address space spread across the slots instead of colliding on their low bits. The lookup is purely combinational. A fetch stage can present an address and read the real address, a translation-valid flag, a privilege-fault flag and a combined access-ok flag in the same cycle.

A memory-management unit keeps the contents up to date through a single update port, which has three requests:

- write an entry (tag and page-table entry) into the slot its address hashes to;
- clear the valid bit of one slot;
- clear the valid bits of all slots.

When translation is off (real mode), the block passes the low address bits straight through. In that mode privilege is always required.

Top module: `ifetch_tlb`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, so a virtual-mode lookup reports `xlate_ok` = 0 until a slot is loaded.
- R2: The slot index of an address is `ea[17:12] ^ ea[23:18] ^ ea[29:24]` (three index-width slices starting just above the 12 page-offset bits). Two addresses with equal index share one slot.
- R3: A load request stores `up_ea[63:18]` as the tag and `up_pte` as the entry at the hashed slot, and marks that slot valid from the next clock edge.
- R4: In virtual mode, `real_addr` = {`pte[55:12]`, `lk_ea[11:0]`} of the slot that `lk_ea` hashes to. `xlate_ok` is 1 only if that slot is valid and its tag equals `lk_ea[63:18]`.
- R5: When a load writes a slot that holds an alias with a different tag, the alias is replaced. A lookup whose tag differs from the stored tag reports `xlate_ok` = 0.
- R6: A single invalidate clears the valid bit at the hashed slot of `up_ea` whatever tag that slot holds. All other slots are left unchanged.
- R7: A global invalidate clears every valid bit at the next clock edge.
- R8: Update requests have a fixed priority: global invalidate, then single invalidate, then load. When several are asserted in one cycle, only the highest takes effect, and a lower-priority load writes nothing.
- R9: In real mode (`lk_virt` = 0), `real_addr` = `lk_ea[55:0]`, `xlate_ok` = 1 and privilege is required.
- R10: In virtual mode, privilege is required when bit 3 of the slot's entry is 1. `priv_fault` = 1 when privilege is required and `lk_priv` = 0.
- R11: `access_ok` = 1 exactly when `xlate_ok` = 1 and `priv_fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_ea | input | 64 | Effective fetch address to translate |
| lk_virt | input | 1 | 1 = translate (virtual mode), 0 = real mode |
| lk_priv | input | 1 | Requester is in privileged mode |
| up_load | input | 1 | Write tag and entry for `up_ea` |
| up_inval_one | input | 1 | Invalidate the slot of `up_ea` |
| up_inval_all | input | 1 | Invalidate every slot |
| up_ea | input | 64 | Address of the update |
| up_pte | input | 64 | Page-table entry to store on load |
| real_addr | output | 56 | Translated real address |
| xlate_ok | output | 1 | Translation valid |
| priv_fault | output | 1 | Privilege violation |
| access_ok | output | 1 | Translation valid and no fault |

## Verification
The properties assume two things about the inputs: the update strobes and the mode inputs are clean 0/1 values, and every lookup address is a known value. The properties that follow an update compare the present lookup address with the update address of the previous cycle. They therefore take for granted that the slot state seen one cycle later comes only from that update. This holds because an update in the present cycle has not yet reached the combinational lookup. The stimulus holds every strobe low during reset and issues at most one update step per cycle. It changes inputs only on the falling edge, so each lookup reads state that one known update has settled.

// File: rtl/ifetch_tlb_pkg.sv
// Package: shared types for the instruction translation buffer.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package ifetch_tlb_pkg;

    // Resolved update action after priority selection
    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_LOAD     = 2'd1,
        UPD_KILL_ONE = 2'd2,
        UPD_KILL_ALL = 2'd3
    } upd_op_e;

endpackage

// File: rtl/ifetch_tlb_hash.sv
// Module: ifetch_tlb_hash
// Folds three adjacent index-wide slices of the page number (starting just
// above the page offset) with XOR into a slot index.
// Assumes PAGE_SHIFT + 3*IDX_W <= EA_W.
module ifetch_tlb_hash #(
    parameter int EA_W       = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int IDX_W      = 6
) (
    input  logic [EA_W-1:0]  ea,
    output logic [IDX_W-1:0] idx
);
    localparam int FOLDS = 3;

    // Purpose: XOR all slices together into one index
    always_comb begin
        idx = '0;
        for (int k = 0; k < FOLDS; k++) begin
            idx = idx ^ ea[PAGE_SHIFT + k*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/ifetch_tlb_store.sv
// Module: ifetch_tlb_store
// Entry storage: one tag, one page-table entry and one valid bit per slot.
// The read is asynchronous; writes take effect on the clock edge.
// Assumes the update action arrives already resolved by priority.
module ifetch_tlb_store
    import ifetch_tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 46,
    parameter int PTE_W   = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_op_e          op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PTE_W-1:0] wr_pte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PTE_W-1:0] rd_pte,
    output logic             rd_valid
);
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PTE_W-1:0]   pte_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    // Purpose: maintain per-slot valid bits under reset and update actions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            unique case (op)
                UPD_KILL_ALL: valid_q         <= '0;
                UPD_KILL_ONE: valid_q[wr_idx] <= 1'b0;
                UPD_LOAD:     valid_q[wr_idx] <= 1'b1;
                default:      valid_q         <= valid_q;
            endcase
        end
    end

    // Purpose: write tag and entry payload on a load (payload has no reset)
    always_ff @(posedge clk) begin
        if (rst_n && op == UPD_LOAD) begin
            tag_q[wr_idx] <= wr_tag;
            pte_q[wr_idx] <= wr_pte;
        end
    end

    // Purpose: asynchronous read of the addressed slot
    always_comb begin
        rd_tag   = tag_q[rd_idx];
        rd_pte   = pte_q[rd_idx];
        rd_valid = valid_q[rd_idx];
    end
endmodule

// File: rtl/ifetch_tlb_xlate.sv
// Module: ifetch_tlb_xlate
// Forms the real address, the valid flag and the privilege decision from
// the slot read for the lookup address and the mode inputs.
// Assumes RA_W <= PTE_W and PRIV_BIT < PAGE_SHIFT.
module ifetch_tlb_xlate #(
    parameter int EA_W       = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int RA_W       = 56,
    parameter int PTE_W      = 64,
    parameter int TAG_W      = 46,
    parameter int PRIV_BIT   = 3
) (
    input  logic [EA_W-1:0]  ea,
    input  logic             virt,
    input  logic             priv,
    input  logic [TAG_W-1:0] slot_tag,
    input  logic [PTE_W-1:0] slot_pte,
    input  logic             slot_valid,
    output logic [RA_W-1:0]  real_addr,
    output logic             xlate_ok,
    output logic             priv_fault,
    output logic             access_ok
);
    logic need_priv;

    // Purpose: choose translated or pass-through address and validity
    always_comb begin
        if (virt) begin
            real_addr = {slot_pte[RA_W-1:PAGE_SHIFT], ea[PAGE_SHIFT-1:0]};
            xlate_ok  = slot_valid && (slot_tag == ea[EA_W-1:EA_W-TAG_W]);
            need_priv = slot_pte[PRIV_BIT];
        end else begin
            real_addr = ea[RA_W-1:0];
            xlate_ok  = 1'b1;
            need_priv = 1'b1;
        end
    end

    // Purpose: privilege rule and combined permission
    always_comb begin
        priv_fault = need_priv && !priv;
        access_ok  = xlate_ok && !priv_fault;
    end
endmodule

// File: rtl/ifetch_tlb.sv
// Module: ifetch_tlb (top)
// Direct-mapped instruction translation buffer with hashed index,
// combinational lookup and a prioritised update port.
// Assumes update strobes are held low while rst_n is low.
module ifetch_tlb
    import ifetch_tlb_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int RA_W       = 56,
    parameter int PTE_W      = 64,
    parameter int EA_W       = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EA_W-1:0] lk_ea,
    input  logic            lk_virt,
    input  logic            lk_priv,
    input  logic            up_load,
    input  logic            up_inval_one,
    input  logic            up_inval_all,
    input  logic [EA_W-1:0] up_ea,
    input  logic [PTE_W-1:0] up_pte,
    output logic [RA_W-1:0] real_addr,
    output logic            xlate_ok,
    output logic            priv_fault,
    output logic            access_ok
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = EA_W - PAGE_SHIFT - IDX_W;
    localparam int NPORT = 2;   // 0: lookup, 1: update

    logic [EA_W-1:0]  hash_in  [NPORT];
    logic [IDX_W-1:0] hash_out [NPORT];
    upd_op_e          op;
    logic [TAG_W-1:0] slot_tag;
    logic [PTE_W-1:0] slot_pte;
    logic             slot_valid;

    assign hash_in[0] = lk_ea;
    assign hash_in[1] = up_ea;

    // One hash unit per address port
    for (genvar p = 0; p < NPORT; p++) begin : g_hash
        ifetch_tlb_hash #(
            .EA_W(EA_W), .PAGE_SHIFT(PAGE_SHIFT), .IDX_W(IDX_W)
        ) u_hash (
            .ea(hash_in[p]),
            .idx(hash_out[p])
        );
    end

    // Purpose: resolve simultaneous update requests by fixed priority
    always_comb begin
        if (up_inval_all)      op = UPD_KILL_ALL;
        else if (up_inval_one) op = UPD_KILL_ONE;
        else if (up_load)      op = UPD_LOAD;
        else                   op = UPD_NONE;
    end

    ifetch_tlb_store #(
        .ENTRIES(ENTRIES), .TAG_W(TAG_W), .PTE_W(PTE_W)
    ) u_store (
        .clk(clk),
        .rst_n(rst_n),
        .op(op),
        .wr_idx(hash_out[1]),
        .wr_tag(up_ea[EA_W-1:EA_W-TAG_W]),
        .wr_pte(up_pte),
        .rd_idx(hash_out[0]),
        .rd_tag(slot_tag),
        .rd_pte(slot_pte),
        .rd_valid(slot_valid)
    );

    ifetch_tlb_xlate #(
        .EA_W(EA_W), .PAGE_SHIFT(PAGE_SHIFT), .RA_W(RA_W),
        .PTE_W(PTE_W), .TAG_W(TAG_W), .PRIV_BIT(3)
    ) u_xlate (
        .ea(lk_ea),
        .virt(lk_virt),
        .priv(lk_priv),
        .slot_tag(slot_tag),
        .slot_pte(slot_pte),
        .slot_valid(slot_valid),
        .real_addr(real_addr),
        .xlate_ok(xlate_ok),
        .priv_fault(priv_fault),
        .access_ok(access_ok)
    );
endmodule

// File: rtl/ifetch_tlb_sva.sv
// Module: ifetch_tlb_sva
// Property checker for ifetch_tlb, attached by bind below.
// Assumes inputs change away from the rising edge.
module ifetch_tlb_sva #(
    parameter int PAGE_SHIFT = 12,
    parameter int RA_W       = 56,
    parameter int PTE_W      = 64,
    parameter int EA_W       = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [EA_W-1:0]  lk_ea,
    input logic             lk_virt,
    input logic             lk_priv,
    input logic             up_load,
    input logic             up_inval_one,
    input logic             up_inval_all,
    input logic [EA_W-1:0]  up_ea,
    input logic [PTE_W-1:0] up_pte,
    input logic [RA_W-1:0]  real_addr,
    input logic             xlate_ok,
    input logic             priv_fault,
    input logic             access_ok
);
    // R1: first cycle out of reset, nothing translates
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && lk_virt |-> !xlate_ok);

    // R3: an accepted load is visible on the next lookup of that address
    a_r3_load_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && up_load && !up_inval_one && !up_inval_all)
        && lk_virt && lk_ea == $past(up_ea)
        |-> xlate_ok && real_addr[RA_W-1:PAGE_SHIFT] == $past(up_pte[RA_W-1:PAGE_SHIFT]));

    // R4: page offset passes through in virtual mode
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_virt |-> real_addr[PAGE_SHIFT-1:0] == lk_ea[PAGE_SHIFT-1:0]);

    // R6: single invalidate kills that address
    a_r6_kill_one: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && up_inval_one && !up_inval_all)
        && lk_virt && lk_ea == $past(up_ea) |-> !xlate_ok);

    // R7: global invalidate kills everything
    a_r7_kill_all: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && up_inval_all) && lk_virt |-> !xlate_ok);

    // R9: real mode passes the address and always translates
    a_r9_real_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_virt |-> xlate_ok && real_addr == lk_ea[RA_W-1:0]);

    // R9: real mode requires privilege
    a_r9_real_needs_priv: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_virt && !lk_priv |-> priv_fault);

    // R10: a fault only arises for an unprivileged requester
    a_r10_fault_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> !lk_priv);

    // R11: permission implies translation and no fault
    a_r11_access: assert property (@(posedge clk) disable iff (!rst_n)
        access_ok |-> xlate_ok && !priv_fault);
endmodule

bind ifetch_tlb ifetch_tlb_sva #(
    .PAGE_SHIFT(PAGE_SHIFT), .RA_W(RA_W), .PTE_W(PTE_W), .EA_W(EA_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .lk_virt(lk_virt),
    .lk_priv(lk_priv), .up_load(up_load), .up_inval_one(up_inval_one),
    .up_inval_all(up_inval_all), .up_ea(up_ea), .up_pte(up_pte),
    .real_addr(real_addr), .xlate_ok(xlate_ok), .priv_fault(priv_fault),
    .access_ok(access_ok)
);

// File: tb/ifetch_tlb_bench.sv
// Bench for ifetch_tlb: table walk of update/lookup steps, then directed
// reset checks.
module ifetch_tlb_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic [2:0]  op;     // 0 none,1 load,2 inv1,3 invall,4 load+inv1,5 load+invall
        logic [63:0] up_ea;
        logic [63:0] up_pte;
        logic [63:0] lk_ea;
        logic        virt;
        logic        priv;
        logic        ok;
        logic        flt;
        logic        acc;
        logic [55:0] ra;
    } vec_t;

    localparam logic [63:0] EA_A = 64'h0000_0000_0000_5000; // slot 5
    localparam logic [63:0] EA_B = 64'h0000_0000_0104_5000; // slot 5, other tag
    localparam logic [63:0] EA_C = 64'hABCD_0000_0000_7123; // slot 7
    localparam logic [63:0] EA_D = 64'h0000_0000_3F56_A000; // slot 0 via fold
    localparam logic [63:0] PTE_A = 64'h0000_0000_0012_3008; // bit3=1
    localparam logic [63:0] PTE_B = 64'h0000_0000_0456_7000;
    localparam logic [63:0] PTE_C = 64'hFF00_0000_0ABC_D000;
    localparam logic [63:0] PTE_D = 64'h0000_0000_0000_1000;
    localparam logic [63:0] EA_R  = 64'hFFFF_1234_5678_9ABC;

    localparam vec_t TBL [NV] = '{
        '{3'd1, EA_A, PTE_A, EA_A | 64'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 56'h12303C},   // R3 R4
        '{3'd0, 64'h0, 64'h0, EA_A | 64'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 56'h12303C},  // R10 R11
        '{3'd1, EA_C, PTE_C, EA_C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 56'hABCD123},           // R4 upper tag
        '{3'd0, 64'h0, 64'h0, EA_B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 56'h123000},           // R5 mismatch
        '{3'd1, EA_B, PTE_B, EA_A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 56'h4567000},           // R5 alias replaced
        '{3'd0, 64'h0, 64'h0, EA_B | 64'hFFC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 56'h4567FFC},// R2 shared slot
        '{3'd2, EA_A, 64'h0, EA_B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 56'h4567000},           // R6 no tag check
        '{3'd0, 64'h0, 64'h0, EA_C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 56'hABCD123},          // R6 others kept
        '{3'd4, EA_A, PTE_A, EA_A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 56'h4567000},           // R8 load dropped
        '{3'd5, EA_A, PTE_A, EA_C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 56'hABCD123},           // R7 R8
        '{3'd0, 64'h0, 64'h0, EA_A, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 56'h4567000},          // R8 no write
        '{3'd0, 64'h0, 64'h0, EA_R, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 56'hFF_1234_5678_9ABC},// R9
        '{3'd0, 64'h0, 64'h0, EA_R, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 56'hFF_1234_5678_9ABC},// R9 R10
        '{3'd1, EA_D, PTE_D, EA_D, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 56'h1000},              // R2 fold
        '{3'd0, 64'h0, 64'h0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 56'h1000}             // R2 slot 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lk_ea = '0;
    logic        lk_virt = 1'b0;
    logic        lk_priv = 1'b0;
    logic        up_load = 1'b0;
    logic        up_inval_one = 1'b0;
    logic        up_inval_all = 1'b0;
    logic [63:0] up_ea = '0;
    logic [63:0] up_pte = '0;
    logic [55:0] real_addr;
    logic        xlate_ok, priv_fault, access_ok;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifetch_tlb u_ifetch_tlb (
        .clk(clk), .rst_n(rst_n), .lk_ea(lk_ea), .lk_virt(lk_virt),
        .lk_priv(lk_priv), .up_load(up_load), .up_inval_one(up_inval_one),
        .up_inval_all(up_inval_all), .up_ea(up_ea), .up_pte(up_pte),
        .real_addr(real_addr), .xlate_ok(xlate_ok), .priv_fault(priv_fault),
        .access_ok(access_ok)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic update(input logic [2:0] op, input logic [63:0] ea, input logic [63:0] pte);
        @(negedge clk);
        up_ea        = ea;
        up_pte       = pte;
        up_load      = (op == 3'd1) || (op == 3'd4) || (op == 3'd5);
        up_inval_one = (op == 3'd2) || (op == 3'd4);
        up_inval_all = (op == 3'd3) || (op == 3'd5);
        @(negedge clk);
        up_load = 1'b0; up_inval_one = 1'b0; up_inval_all = 1'b0;
    endtask

    task automatic look(input logic [63:0] ea, input logic v, input logic p);
        lk_ea = ea; lk_virt = v; lk_priv = p;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        look(EA_A, 1'b1, 1'b1);
        chk("R1 xlate_ok in reset", {63'd0, xlate_ok}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        look(EA_C, 1'b1, 1'b1);
        chk("R1 xlate_ok after reset", {63'd0, xlate_ok}, 64'd0);
        chk("R1 access_ok after reset", {63'd0, access_ok}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            update(TBL[i].op, TBL[i].up_ea, TBL[i].up_pte);
            look(TBL[i].lk_ea, TBL[i].virt, TBL[i].priv);
            chk($sformatf("R4 xlate_ok row %0d", i), {63'd0, xlate_ok}, {63'd0, TBL[i].ok});
            chk($sformatf("R10 priv_fault row %0d", i), {63'd0, priv_fault}, {63'd0, TBL[i].flt});
            chk($sformatf("R11 access_ok row %0d", i), {63'd0, access_ok}, {63'd0, TBL[i].acc});
            chk($sformatf("R4 real_addr row %0d", i), {8'd0, real_addr}, {8'd0, TBL[i].ra});
        end

        // R1: a second reset empties a loaded buffer
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(EA_D, 1'b1, 1'b0);
        chk("R1 xlate_ok after re-reset", {63'd0, xlate_ok}, 64'd0);

        // R7 over R6: both invalidates together after reloading two slots
        update(3'd1, EA_C, PTE_C);
        update(3'd1, EA_D, PTE_D);
        look(EA_C, 1'b1, 1'b0);
        chk("R3 reload C", {63'd0, xlate_ok}, 64'd1);
        @(negedge clk);
        up_ea = EA_D; up_inval_one = 1'b1; up_inval_all = 1'b1;
        @(negedge clk);
        up_inval_one = 1'b0; up_inval_all = 1'b0;
        look(EA_C, 1'b1, 1'b0);
        chk("R7 C cleared by global", {63'd0, xlate_ok}, 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule